// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port word memory. Its read and write paths are both pipelined, so the data beat for any command sits on the bus the same number of cycles after the command. A write's data trails its address exactly as a read's data does. This means reads and writes can be issued in any order on every cycle, and the shared bus never needs an idle turnaround slot.

A command is an address, a direction and per-byte write enables. It is accepted on a rising clock edge while the active-low clock enable is low. A separate generator supplies the burst addresses. This core only keeps the direction of the last loaded command, so that advance cycles can continue it.

The bidirectional data bus is split into `dq_i`, `dq_o` and `dq_oe_o`. An active-low asynchronous output enable can force the drive off at any time.

Top module: `zbt_sram_core`

## Requirements
- R1: Only edges with `cke_ni` low count as enabled edges. Take a command accepted at enabled edge E0, and let E2 be the second enabled edge after E0. A read drives its word on `dq_o` from E2 until the next enabled edge E3. A write takes its word from `dq_i` at E3.
- R2: Any sequence of reads and writes, at any addresses, may be accepted on consecutive enabled edges. Each one completes per R1 with no idle cycle in between.
- R3: While `cke_ni` is high, the block ignores every other synchronous input. It holds every pipeline stage and `dq_o`, and it writes nothing to memory.
- R4: A new command loads only when `adv_i` is 0 and all three bits of `cs_i` are 1. A load cycle with any bit of `cs_i` at 0 starts nothing. Commands already accepted still complete.
- R5: When `adv_i` is 1, the block starts a command in the direction of the last load, at the current `addr_i`, with the current `be_i`. It does this only if that last load started a command. Otherwise it starts nothing.
- R6: Bit i of `be_i` enables writing of bits [8i+7:8i]. It is sampled together with the command. A write with a bit at 0 leaves that byte of memory unchanged.
- R7: A read returns the newest data for its address. This includes bytes written by a write accepted one or two enabled edges earlier, merged per byte with the stored word.
- R8: `dq_oe_o` is 1 only during a read's data cycle (per R1) while `oe_ni` is 0. It is 0 during a write's data cycle and in cycles with no command in the data stage.
- R9: `oe_ni` acts without a clock. Raising it drops `dq_oe_o` at once, and lowering it restores the drive, with no effect on the pipeline.
- R10: While `rst_ni` is low, the pipeline is empty and `dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high stalls the block |
| cs_i | input | 3 | Chip selects; all must be 1 to load |
| wr_i | input | 1 | Direction of a loaded command: 1 write, 0 read |
| adv_i | input | 1 | 0 loads a new command, 1 continues the last one |
| be_i | input | NB (4) | Per-byte write enables |
| addr_i | input | AW (6) | Word address |
| dq_i | input | 8*NB (32) | Write data from the bus |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_o | output | 8*NB (32) | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable for dq_o |

## Verification
The memory is first filled with full-word writes. Directed sequences then isolate single effects:
- a write followed by reads of the same address one, two and three cycles later, which separates forwarding from the stored path;
- a write with no byte enabled;
- a stall inserted between a read command and its data cycle;
- deselected load cycles behind a pending read;
- advance cycles after both an active load and a deselected load.

A long run with a fixed seed follows. It draws commands mostly from a few addresses so that write-to-read hazards are frequent, and mixes in random stalls, partial deselects, advance cycles and output-enable pulses. A bench model predicts every bus cycle. Inside read data cycles, the output enable is also toggled asynchronously.

// File: rtl/zsc_pkg.sv
package zsc_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;
endpackage

// File: rtl/zsc_cmd_pipe.sv
module zsc_cmd_pipe
  import zsc_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic [2:0]    cs_i,
  input  logic          wr_i,
  input  logic          adv_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          dat_valid_o,
  output op_e           dat_op_o,
  output logic [AW-1:0] dat_addr_o,
  output logic [NB-1:0] dat_be_o
);
  localparam int STAGES = 3;
  localparam int LAST   = STAGES - 1;

  logic              last_act_q;
  op_e               last_op_q;
  logic              new_v;
  op_e               new_op;
  logic [STAGES-1:0] v_q;
  op_e               op_q [STAGES];
  logic [AW-1:0]     a_q  [STAGES];
  logic [NB-1:0]     be_q [STAGES];

  always_comb begin
    if (!adv_i) begin
      new_v  = &cs_i;
      new_op = wr_i ? OP_WR : OP_RD;
    end else begin
      new_v  = last_act_q;
      new_op = last_op_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q        <= '0;
      last_act_q <= 1'b0;
      last_op_q  <= OP_RD;
      for (int i = 0; i < STAGES; i++) begin
        op_q[i] <= OP_RD;
        a_q[i]  <= '0;
        be_q[i] <= '0;
      end
    end else if (!cke_ni) begin
      if (!adv_i) begin
        last_act_q <= &cs_i;
        last_op_q  <= new_op;
      end
      v_q[0]  <= new_v;
      op_q[0] <= new_op;
      a_q[0]  <= addr_i;
      be_q[0] <= be_i;
      for (int i = 1; i < STAGES; i++) begin
        v_q[i]  <= v_q[i-1];
        op_q[i] <= op_q[i-1];
        a_q[i]  <= a_q[i-1];
        be_q[i] <= be_q[i-1];
      end
    end
  end

  // read address is the stage before the data stage
  assign rd_addr_o   = a_q[LAST-1];
  assign dat_valid_o = v_q[LAST];
  assign dat_op_o    = op_q[LAST];
  assign dat_addr_o  = a_q[LAST];
  assign dat_be_o    = be_q[LAST];

  p_load_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && !(&cs_i)) |=> !v_q[0]);

  p_cont_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_i && !last_act_q) |=> !v_q[0]);

  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_ni |=> (v_q[LAST] == $past(v_q[LAST-1]) && a_q[LAST] == $past(a_q[LAST-1])));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(v_q) && $stable(a_q[LAST]) && $stable(last_act_q)));
endmodule

// File: rtl/zsc_store.sv
module zsc_store #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_ni,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [NB-1:0]   wr_be_i,
  input  logic [8*NB-1:0] wdata_i,
  output logic [8*NB-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 8 * NB;

  logic [DW-1:0] rd_next;
  logic [NB-1:0] hit;
  logic [DW-1:0] rdata_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (!cke_ni && wr_en_i && wr_be_i[g]) lane_q[wr_addr_i] <= wdata_i[8*g +: 8];
    end

    // bypass the byte committing on this same edge
    assign hit[g] = wr_en_i && wr_be_i[g] && (wr_addr_i == rd_addr_i);
    assign rd_next[8*g +: 8] = hit[g] ? wdata_i[8*g +: 8] : lane_q[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (!cke_ni) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  p_fwd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && wr_en_i && (&wr_be_i) && wr_addr_i == rd_addr_i) |=> rdata_o == $past(wdata_i));

  p_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> $stable(rdata_o));
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zsc_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_ni,
  input  logic [2:0]      cs_i,
  input  logic            wr_i,
  input  logic            adv_i,
  input  logic [NB-1:0]   be_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [8*NB-1:0] dq_i,
  input  logic            oe_ni,
  output logic [8*NB-1:0] dq_o,
  output logic            dq_oe_o
);
  logic [AW-1:0] rd_addr;
  logic          dat_valid;
  op_e           dat_op;
  logic [AW-1:0] dat_addr;
  logic [NB-1:0] dat_be;
  logic          wr_commit;

  zsc_cmd_pipe #(.AW(AW), .NB(NB)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_ni      (cke_ni),
    .cs_i        (cs_i),
    .wr_i        (wr_i),
    .adv_i       (adv_i),
    .be_i        (be_i),
    .addr_i      (addr_i),
    .rd_addr_o   (rd_addr),
    .dat_valid_o (dat_valid),
    .dat_op_o    (dat_op),
    .dat_addr_o  (dat_addr),
    .dat_be_o    (dat_be)
  );

  assign wr_commit = dat_valid && (dat_op == OP_WR);

  zsc_store #(.AW(AW), .NB(NB)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cke_ni    (cke_ni),
    .rd_addr_i (rd_addr),
    .wr_en_i   (wr_commit),
    .wr_addr_i (dat_addr),
    .wr_be_i   (dat_be),
    .wdata_i   (dq_i),
    .rdata_o   (dq_o)
  );

  assign dq_oe_o = dat_valid && (dat_op == OP_RD) && !oe_ni;

  p_nodrive_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && u_cmd.v_q[1] && u_cmd.op_q[1] == OP_WR) |=> !dq_oe_o);

  p_reset_idle_r10: assert property (@(posedge clk_i)
    !rst_ni |-> !dq_oe_o);
endmodule

// File: tb/zbt_sram_core_test.sv
module zbt_sram_core_test;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cke_ni = 1'b0;
  logic [2:0]    cs_i = 3'b000;
  logic          wr_i = 1'b0;
  logic          adv_i = 1'b0;
  logic [NB-1:0] be_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] dq_i = '0;
  logic          oe_ni = 1'b0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "reset";

  // bench model of the pipeline, derived from R1..R8
  bit            m_v  [3];
  bit            m_w  [3];
  logic [AW-1:0] m_a  [3];
  logic [NB-1:0] m_be [3];
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] exp_rd = '0;
  bit            m_last_act = 0;
  bit            m_last_wr = 0;

  zbt_sram_core #(.AW(AW), .NB(NB)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_ni(cke_ni), .cs_i(cs_i), .wr_i(wr_i),
    .adv_i(adv_i), .be_i(be_i), .addr_i(addr_i), .dq_i(dq_i), .oe_ni(oe_ni),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %h expected %h", req, cur_tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit nv, nw;
    if (cke_ni) return;  // R3: stall holds everything
    if (m_v[2] && m_w[2])
      for (int b = 0; b < NB; b++)
        if (m_be[2][b]) m_mem[m_a[2]][8*b +: 8] = dq_i[8*b +: 8];
    if (!adv_i) begin
      nv = (cs_i == 3'b111); nw = wr_i;
      m_last_act = nv; m_last_wr = nw;
    end else begin
      nv = m_last_act; nw = m_last_wr;
    end
    for (int i = 2; i > 0; i--) begin
      m_v[i] = m_v[i-1]; m_w[i] = m_w[i-1]; m_a[i] = m_a[i-1]; m_be[i] = m_be[i-1];
    end
    m_v[0] = nv; m_w[0] = nw; m_a[0] = addr_i; m_be[0] = be_i;
    if (m_v[2] && !m_w[2]) exp_rd = m_mem[m_a[2]];
  endtask

  task automatic check_out();
    bit exp_oe;
    exp_oe = m_v[2] && !m_w[2] && !oe_ni;
    check(dq_oe_o == exp_oe, "bus drive (R8)", {31'd0, dq_oe_o}, {31'd0, exp_oe});
    if (exp_oe) begin
      check(dq_o == exp_rd, "read data (R1)", dq_o, exp_rd);
      if ($urandom_range(0, 3) == 0) begin
        oe_ni = 1'b1; #1;
        check(dq_oe_o == 1'b0, "async off (R9)", {31'd0, dq_oe_o}, 32'd0);
        oe_ni = 1'b0; #1;
        check(dq_oe_o == 1'b1, "async on (R9)", {31'd0, dq_oe_o}, 32'd1);
        check(dq_o == exp_rd, "data kept (R9)", dq_o, exp_rd);
      end
    end
  endtask

  task automatic cyc(input bit cke, input bit adv, input logic [2:0] cs, input bit wr,
                     input logic [NB-1:0] be, input logic [AW-1:0] a, input bit oe);
    @(negedge clk_i);
    check_out();
    cke_ni = cke; adv_i = adv; cs_i = cs; wr_i = wr; be_i = be; addr_i = a;
    dq_i = $urandom; oe_ni = oe;
    @(posedge clk_i); #1;
    model_edge();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'b000, 0, '0, '0, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) begin m_v[i] = 0; m_w[i] = 0; m_a[i] = '0; m_be[i] = '0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10: reset state
    check(dq_oe_o == 1'b0, "reset idle (R10)", {31'd0, dq_oe_o}, 32'd0);
    rst_ni = 1'b1;

    cur_tag = "fill";  // R2: writes every cycle
    for (int a = 0; a < DEPTH; a++) cyc(0, 0, 3'b111, 1, '1, a[AW-1:0], 0);
    idle(3);
    cur_tag = "readback";  // R1
    for (int a = 0; a < DEPTH; a += 5) cyc(0, 0, 3'b111, 0, '0, a[AW-1:0], 0);
    idle(3);

    cur_tag = "R7 forwarding";
    cyc(0, 0, 3'b111, 1, 4'b0011, 6'd5, 0);
    cyc(0, 0, 3'b111, 0, 4'b0000, 6'd5, 0);
    cyc(0, 0, 3'b111, 0, 4'b0000, 6'd5, 0);
    cyc(0, 0, 3'b111, 0, 4'b0000, 6'd5, 0);
    cyc(0, 0, 3'b111, 1, 4'b1000, 6'd5, 0);
    cyc(0, 0, 3'b111, 1, 4'b0100, 6'd5, 0);
    cyc(0, 0, 3'b111, 0, 4'b0000, 6'd5, 0);
    idle(3);

    cur_tag = "R6 no bytes";
    cyc(0, 0, 3'b111, 1, 4'b0000, 6'd9, 0);
    cyc(0, 0, 3'b111, 0, 4'b1111, 6'd9, 0);
    idle(3);

    cur_tag = "R3 stall";
    cyc(0, 0, 3'b111, 0, '0, 6'd12, 0);
    cyc(0, 0, 3'b111, 1, '1, 6'd12, 0);
    for (int i = 0; i < 3; i++) cyc(1, $urandom_range(0, 1), 3'b111, 1, '1, 6'd12, 0);
    idle(2);
    cyc(0, 0, 3'b111, 0, '0, 6'd12, 0);
    idle(3);

    cur_tag = "R4 deselect";
    cyc(0, 0, 3'b111, 0, '0, 6'd20, 0);
    cyc(0, 0, 3'b110, 1, '1, 6'd20, 0);
    cyc(0, 0, 3'b011, 1, '1, 6'd20, 0);
    cyc(0, 0, 3'b101, 0, '1, 6'd20, 0);
    cyc(0, 0, 3'b111, 0, '0, 6'd20, 0);
    idle(3);

    cur_tag = "R5 continue";
    cyc(0, 0, 3'b111, 1, '1, 6'd30, 0);
    cyc(0, 1, 3'b000, 0, '1, 6'd31, 0);
    cyc(0, 1, 3'b000, 0, 4'b0110, 6'd32, 0);
    cyc(0, 0, 3'b111, 0, '0, 6'd30, 0);
    cyc(0, 1, 3'b000, 1, '0, 6'd31, 0);
    cyc(0, 1, 3'b000, 1, '0, 6'd32, 0);
    cyc(0, 0, 3'b001, 0, '0, 6'd33, 0);
    cyc(0, 1, 3'b111, 0, '0, 6'd30, 0);
    cyc(0, 1, 3'b111, 1, '1, 6'd31, 0);
    idle(3);

    cur_tag = "R8 oe gating";
    cyc(0, 0, 3'b111, 0, '0, 6'd2, 1);
    cyc(0, 0, 3'b111, 0, '0, 6'd3, 1);
    cyc(0, 0, 3'b111, 1, '1, 6'd4, 1);
    idle(3);

    cur_tag = "R2 random mix";
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] cs;
      cs = ($urandom_range(0, 6) == 0) ? 3'($urandom_range(0, 6)) : 3'b111;
      cyc($urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0, cs, $urandom_range(0, 1),
          NB'($urandom), AW'($urandom_range(0, 7)), $urandom_range(0, 9) == 0);
    end
    idle(4);
    @(negedge clk_i);
    check_out();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule